// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address that missed in the translation buffer into a physical address. It does this by walking a two-level page table held in memory. A request carries the full virtual address and the base address of the root table. The walker first reads the root-table entry selected by the upper index field. If that entry is present, it names the frame of a second-level table. The walker then reads the second-level entry selected by the middle index field. A present second-level entry supplies the physical frame, which is joined to the untouched page offset.

A root entry that is null or not present ends the walk right away with a fault tagged as level one, and no second read is made. A leaf entry that is not present ends the walk with a fault tagged as level two. The block has one memory read port that uses a valid/ready request and a variable-latency response. It keeps at most one read outstanding, and it takes a new walk only when it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0.
- R2: The 32-bit virtual address is split as follows: bits 31:22 index the root table, bits 21:12 index the second-level table, and bits 11:0 are the page offset. Pages are 4 KB.
- R3: The first read goes to req_root + 4 * va[31:22]. Each entry is 4 bytes.
- R4: An entry is valid when bit 0 is 1. Bits 31:12 hold a frame number. If the root entry is not valid (a null entry counts as not valid), the walk responds with rsp_fault=1 and rsp_level=1 after exactly one read.
- R5: The second read is issued only after the first read's data has arrived. It goes to (frame of the root entry << 12) + 4 * va[21:12].
- R6: If the second-level entry is not valid, the walk responds with rsp_fault=1 and rsp_level=2 after exactly two reads.
- R7: On success, the response has rsp_fault=0, rsp_level=0 and rsp_paddr = {leaf frame, va[11:0]}.
- R8: A read request holds mem_req_valid and a stable mem_req_addr until mem_req_ready is seen. No new read is requested while a read is outstanding.
- R9: A mem_rsp_valid pulse that arrives while no read is outstanding is ignored.
- R10: req_ready is 1 only while idle. A request presented during a walk is not accepted, and it causes no memory reads and no response.
- R11: rsp_valid is a one-cycle pulse. It rises in the cycle after the clock edge that captures the final read data, and the walker is idle in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the root table |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Walk result present, for one cycle |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_level | output | 2 | 0 when no fault, 1 for a root-level fault, 2 for a leaf-level fault |
| rsp_paddr | output | 32 | Translated physical address, 0 on a fault |

## Verification
The bench aims at the extremes of the index fields: both indices at 1023 and the leaf index at 0. A design that swapped or shifted the index fields would read the wrong entry addresses, and the per-read address comparison catches this. Root entries that are entirely zero, and root entries that are non-zero but have bit 0 clear, must both stop after one read. A walker that tested the wrong bit would fetch a second entry, or would miss the fault.

The memory model stalls the request port, varies the response latency, and injects response pulses while no read is outstanding. A walker that advanced on those stray pulses would return a garbage frame, and one that dropped its address during a stall would be caught by the hold check. Requests held high throughout a walk test that the walker neither restarts nor produces a second response.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ_L1,
    S_WAIT_L1,
    S_READ_L2,
    S_WAIT_L2,
    S_DONE
  } walk_state_e;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_ROOT = 2'd1;
  localparam logic [1:0] LVL_LEAF = 2'd2;

endpackage

// File: rtl/pt_ent_addr.sv
// Byte address of one table entry: table base plus index scaled by entry size.
module pt_ent_addr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int PTE_W  = 32
) (
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] ent_addr
);
  localparam int ENT_BYTES = PTE_W / 8;
  localparam int ENT_SH    = $clog2(ENT_BYTES);

  assign ent_addr = tbl_base + (ADDR_W'(idx) << ENT_SH);
endmodule

// File: rtl/pt_pte_decode.sv
// Splits a table entry into its present flag and the byte base of its frame.
module pt_pte_decode #(
  parameter int PTE_W  = 32,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic [PTE_W-1:0]  entry,
  output logic              present,
  output logic [ADDR_W-1:0] frame_base
);
  localparam int FRM_W = PTE_W - OFF_W;

  logic [FRM_W-1:0] frame;
  logic             unused_attr;

  assign present     = entry[0];
  assign frame       = entry[PTE_W-1:OFF_W];
  assign frame_base  = ADDR_W'(frame) << OFF_W;
  assign unused_attr = ^entry[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int PTE_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]   req_vaddr,
  input  logic [ADDR_W-1:0]          req_root,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [ADDR_W-1:0]          mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [PTE_W-1:0]           mem_rsp_data,
  output logic                       rsp_valid,
  output logic                       rsp_fault,
  output logic [1:0]                 rsp_level,
  output logic [ADDR_W-1:0]          rsp_paddr
);
  localparam int VA_W  = 2*IDX_W + OFF_W;
  localparam int KEEP_W = IDX_W + OFF_W;

  walk_state_e         state_q;
  logic [KEEP_W-1:0]   va_keep_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                rsp_valid_q;
  logic                rsp_fault_q;
  logic [1:0]          rsp_level_q;
  logic [ADDR_W-1:0]   rsp_paddr_q;

  logic [IDX_W-1:0]    root_idx;
  logic [IDX_W-1:0]    leaf_idx;
  logic [OFF_W-1:0]    page_off;
  logic [ADDR_W-1:0]   root_ent_addr;
  logic [ADDR_W-1:0]   leaf_ent_addr;
  logic                ent_present;
  logic [ADDR_W-1:0]   ent_frame_base;

  assign root_idx = req_vaddr[VA_W-1 -: IDX_W];
  assign leaf_idx = va_keep_q[KEEP_W-1 -: IDX_W];
  assign page_off = va_keep_q[OFF_W-1:0];

  pt_ent_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_root_addr (
    .tbl_base (req_root),
    .idx      (root_idx),
    .ent_addr (root_ent_addr)
  );

  pt_ent_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_leaf_addr (
    .tbl_base (ent_frame_base),
    .idx      (leaf_idx),
    .ent_addr (leaf_ent_addr)
  );

  pt_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_dec (
    .entry      (mem_rsp_data),
    .present    (ent_present),
    .frame_base (ent_frame_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      va_keep_q   <= '0;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_level_q <= LVL_NONE;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            va_keep_q <= req_vaddr[KEEP_W-1:0];
            addr_q    <= root_ent_addr;
            state_q   <= S_READ_L1;
          end
        end
        S_READ_L1: begin
          if (mem_req_ready) state_q <= S_WAIT_L1;
        end
        S_WAIT_L1: begin
          if (mem_rsp_valid) begin
            if (ent_present) begin
              addr_q  <= leaf_ent_addr;
              state_q <= S_READ_L2;
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_level_q <= LVL_ROOT;
              rsp_paddr_q <= '0;
              state_q     <= S_DONE;
            end
          end
        end
        S_READ_L2: begin
          if (mem_req_ready) state_q <= S_WAIT_L2;
        end
        S_WAIT_L2: begin
          if (mem_rsp_valid) begin
            rsp_valid_q <= 1'b1;
            if (ent_present) begin
              rsp_fault_q <= 1'b0;
              rsp_level_q <= LVL_NONE;
              rsp_paddr_q <= ent_frame_base | ADDR_W'(page_off);
            end else begin
              rsp_fault_q <= 1'b1;
              rsp_level_q <= LVL_LEAF;
              rsp_paddr_q <= '0;
            end
            state_q <= S_DONE;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_READ_L1) || (state_q == S_READ_L2);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_fault     = rsp_fault_q;
  assign rsp_level     = rsp_level_q;
  assign rsp_paddr     = rsp_paddr_q;

  // R8: a stalled read keeps its request and address
  a_r8_hold_addr: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8: one read at a time
  a_r8_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R10: busy after taking a walk
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R11: single-cycle result, then idle
  a_r11_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid && req_ready);

  // R4/R6/R7: level tag agrees with the fault flag
  a_r4_level_tag: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_level != LVL_NONE)) && (rsp_level != 2'd3));

  // R5: no read issued while result is being reported
  a_r5_no_read_in_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req_valid);

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic [31:0] rsp_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_paddr(rsp_paddr)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] pmem [logic [31:0]];
  logic [31:0] exp_q[$];
  logic        exp_fault;
  logic [1:0]  exp_level;
  logic [31:0] exp_pa;
  int          exp_reads;

  // engine state
  bit          engine_on = 0;
  bit          busy = 0;
  bit          pending = 0;
  int          cnt = 0;
  logic [31:0] rd_addr = '0;
  int          g_lat = 1;
  int          g_stall = 0;
  int          stall_left = 0;
  bit          spur_en = 0;
  int          nreads = 0;
  int          cyc = 0;
  int          last_data_cyc = -10;
  bit          got_rsp = 0;
  logic        got_fault;
  logic [1:0]  got_level;
  logic [31:0] got_pa;
  logic        prev_hold = 0;
  logic [31:0] prev_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  // behavioural reference of one walk
  task automatic model(input logic [31:0] root, input logic [31:0] va);
    logic [31:0] a1, a2, e1, e2;
    exp_q.delete();
    a1 = root + {20'h0, va[31:22], 2'b00};
    exp_q.push_back(a1);
    e1 = rd(a1);
    if (!e1[0]) begin
      exp_fault = 1; exp_level = 1; exp_pa = 0; exp_reads = 1;
    end else begin
      a2 = {e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
      exp_q.push_back(a2);
      e2 = rd(a2);
      exp_reads = 2;
      if (!e2[0]) begin
        exp_fault = 1; exp_level = 2; exp_pa = 0;
      end else begin
        exp_fault = 0; exp_level = 0; exp_pa = {e2[31:12], va[11:0]};
      end
    end
  endtask

  // memory model and per-clock monitor
  initial begin
    forever begin
      @(negedge clk);
      if (engine_on) begin
        cyc++;
        if (req_ready && busy)
          chk(0, "R10 ready while walking", 64'(req_ready), 64'd0);
        if (mem_req_valid && !busy)
          chk(0, "R10 read without an accepted walk", 64'(mem_req_valid), 64'd0);
        if (mem_req_valid && pending)
          chk(0, "R8 read while one outstanding", 64'(mem_req_valid), 64'd0);
        if (prev_hold)
          chk(mem_req_valid && mem_req_addr == prev_addr, "R8 hold during stall",
              64'(mem_req_addr), 64'(prev_addr));
        if (rsp_valid) begin
          chk(busy, "R11 response without walk", 64'(busy), 64'd1);
          chk(cyc == last_data_cyc + 1, "R11 response timing", 64'(cyc), 64'(last_data_cyc + 1));
          got_rsp = 1; got_fault = rsp_fault; got_level = rsp_level; got_pa = rsp_paddr;
          busy = 0;
        end
        mem_rsp_valid = 0;
        mem_rsp_data  = 32'hDEAD_BEE0;
        if (pending) begin
          mem_req_ready = 0;
          cnt--;
          if (cnt == 0) begin
            mem_rsp_valid = 1;
            mem_rsp_data  = rd(rd_addr);
            pending = 0;
            last_data_cyc = cyc;
          end
        end else if (mem_req_valid) begin
          if (stall_left > 0) begin
            mem_req_ready = 0;
            stall_left--;
          end else begin
            mem_req_ready = 1;
            if (exp_q.size() == 0)
              chk(0, "R5 unexpected extra read", 64'(mem_req_addr), 64'd0);
            else begin
              logic [31:0] ea;
              ea = exp_q.pop_front();
              chk(mem_req_addr == ea, nreads == 0 ? "R3 root entry address" : "R5 leaf entry address",
                  64'(mem_req_addr), 64'(ea));
            end
            nreads++;
            pending = 1;
            cnt = g_lat;
            rd_addr = mem_req_addr;
            stall_left = g_stall;
          end
        end else begin
          mem_req_ready = 0;
        end
        if (spur_en && !pending && !mem_rsp_valid) begin
          mem_rsp_valid = 1;           // R9 stray pulse, valid-looking entry
          mem_rsp_data  = 32'hFFFF_F001;
        end
        prev_hold = mem_req_valid && !mem_req_ready;
        prev_addr = mem_req_addr;
      end
    end
  end

  task automatic walk(input logic [31:0] root, input logic [31:0] va, input int lat,
                      input int stall, input bit spur, input bit hold_req, input string tag);
    int guard;
    model(root, va);
    g_lat = lat; g_stall = stall; stall_left = stall; spur_en = spur;
    nreads = 0; got_rsp = 0;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 1; req_vaddr = va; req_root = root; busy = 1;
    @(negedge clk); #1;
    if (hold_req) req_vaddr = va ^ 32'h0040_1000;  // R10 second request held during walk
    else req_valid = 0;
    guard = 0;
    while (!got_rsp && guard < 200) begin @(negedge clk); #1; guard++; end
    req_valid = 0; spur_en = 0;
    chk(got_rsp, {tag, " response seen"}, 64'(got_rsp), 64'd1);
    chk(got_fault == exp_fault, {tag, " fault flag"}, 64'(got_fault), 64'(exp_fault));
    chk(got_level == exp_level, {tag, " fault level"}, 64'(got_level), 64'(exp_level));
    chk(got_pa == exp_pa, {tag, " physical address"}, 64'(got_pa), 64'(exp_pa));
    chk(nreads == exp_reads, {tag, " read count"}, 64'(nreads), 64'(exp_reads));
    repeat (3) @(negedge clk);
    #1;
    chk(exp_q.size() == 0 && !busy, {tag, " R10 no extra activity"}, 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    pmem[32'h0001_0004] = 32'h0002_0001;
    pmem[32'h0002_000C] = 32'hABCD_E001;
    pmem[32'h0002_0010] = 32'h1234_5000;
    pmem[32'h0001_0008] = 32'h0003_0000;
    pmem[32'h0001_0FFC] = 32'h0004_0001;
    pmem[32'h0004_0FFC] = 32'h7777_7001;
    pmem[32'h0004_0000] = 32'h0000_1001;
    pmem[32'h0008_0000] = 32'h0002_0001;

    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1, "R1 ready in reset", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 0, "R1 no read in reset", 64'(mem_req_valid), 64'd0);
    rst = 0;
    @(negedge clk); #1;
    chk(req_ready == 1 && mem_req_valid == 0 && rsp_valid == 0, "R1 idle after reset",
        64'({req_ready, mem_req_valid, rsp_valid}), 64'h4);
    engine_on = 1;

    walk(32'h0001_0000, 32'h0040_3ABC, 1, 0, 0, 0, "R7 R2 success");
    walk(32'h0001_0000, 32'h0040_4000, 3, 2, 0, 0, "R6 leaf invalid");
    walk(32'h0001_0000, 32'h0080_0FFF, 2, 0, 0, 0, "R4 root nonzero invalid");
    walk(32'h0001_0000, 32'h0140_0000, 1, 1, 1, 0, "R4 root null");
    walk(32'h0001_0000, 32'hFFFF_FFFF, 4, 3, 1, 0, "R2 R9 top indices");
    walk(32'h0001_0000, 32'hFFC0_0000, 2, 1, 1, 1, "R10 R9 leaf index zero");
    walk(32'h0008_0000, 32'h0000_3123, 2, 1, 1, 1, "R7 R3 second root");
    for (int k = 1; k <= 4; k++)
      walk(32'h0001_0000, 32'h0040_3000 + 32'(k * 37), k, 4 - k, k[0], 0, "R8 R11 latency sweep");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule